// File: doc/BRIEF.md
# Dual-Comparator Timer with Compare Output and PWM

The block is a timer built around one up-counter and two comparators. Comparator A checks the whole count against a full-width register. Comparator P checks only the top bits of the count against a short period register. This gives period choices in coarse steps at little comparator cost. A two-bit mode input selects what the block does. In compare-output mode, a match on comparator A changes one output pin. In PWM mode, the pin carries a pulse-width waveform. In plain timer mode, the pin stays idle. In every mode, both comparators raise sticky match flags.

A surrounding register block drives the control inputs. The enable input starts the count. Lowering the enable clears the counter and returns the pin to its idle level. The four control bits are:
- a clear-source select;
- an output-control bit, whose meaning depends on the mode;
- an invert bit;
- a swap bit, which exchanges the period and duty roles of the two registers in PWM mode.

The pin-action field is captured only while the timer is stopped.

Top module: `dct_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `cnt_out` is 0, `pin_out` is 0 and both flags are 0.
- R2: While `en` is 1, the counter rises by one at each clock edge unless a clear event occurs. One edge after `en` is 0, the counter is 0, and it stays 0 while `en` stays 0.
- R3: `mode` encodes the function: 2'b00 selects compare-output mode, 2'b10 selects PWM mode, and 2'b01 and 2'b11 both select plain timer mode.
- R4: In compare-output and timer modes, `clr_on_a`=1 makes the counter return to 0 after the cycle in which it equals `cmp_a`, giving a period of `cmp_a`+1. With `clr_on_a`=0, the counter returns to 0 after the cycle in which it equals `cmp_p`*128-1, giving a period of `cmp_p`*128.
- R5: With `clr_on_a`=0 and `cmp_p`=0, the counter runs through its full 1024-count range and wraps from 1023 to 0.
- R6: While `en` is 1, `flag_a` is set one edge after the count equals `cmp_a`. `flag_p` is set one edge after the count equals (`cmp_p`*128-1) mod 1024. Both flags are set in any mode and for either clear source. A flag stays set until its clear input is 1 on an edge with no new match, and a new match takes priority over a clear.
- R7: In compare-output mode, while `en` is 0, the pin goes to `out_ctl` at the next edge. While running, a comparator A match applies the latched action at the following edge. The action codes are 2'b00 hold, 2'b01 drive low, 2'b10 drive high and 2'b11 toggle.
- R8: `act_in` is captured only on edges where `en` is 0. Changes to `act_in` while the timer runs have no effect on the pin.
- R9: In PWM mode, `swap`=0 uses a period of `cmp_p`*128 (1024 when `cmp_p` is 0) and a duty of `cmp_a`. `swap`=1 uses a period of `cmp_a`+1 and a duty of `cmp_p`*128. The pin is at its active level when the count in the previous cycle was below the duty. `out_ctl`=1 means active-high and `out_ctl`=0 means active-low. While `en` is 0, the pin is inactive. `clr_on_a` has no effect in this mode.
- R10: In compare-output and PWM modes, `out_inv`=1 inverts the final pin value.
- R11: In timer mode, `pin_out` is 0 whatever the values of `out_ctl`, `out_inv` and `act_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| mode | input | 2 | Function select |
| clr_on_a | input | 1 | Clear source: 1 selects comparator A, 0 selects comparator P or overflow |
| out_ctl | input | 1 | Initial level in compare mode, active level in PWM mode |
| out_inv | input | 1 | Invert the pin value |
| swap | input | 1 | PWM role swap between the period and duty registers |
| act_in | input | 2 | Pin action on an A match, captured while stopped |
| cmp_a | input | 10 | Comparator A value |
| cmp_p | input | 3 | Comparator P value, compared with count bits [9:7] |
| flag_clr_a | input | 1 | Clear for flag A |
| flag_clr_p | input | 1 | Clear for flag P |
| pin_out | output | 1 | Registered timer pin |
| flag_a | output | 1 | Sticky comparator A match flag |
| flag_p | output | 1 | Sticky comparator P match flag |
| cnt_out | output | 10 | Current count |

## Verification
The assertions check four rules on every cycle:
- the counter steps by exactly one between nonzero values and returns to zero when the timer is stopped;
- the flags stay set and are set by a comparator A match;
- the pin stays low in timer mode;
- the pin settles to the initial level while compare mode is stopped.

Only the bench scenarios can show the other behaviours. These are the period set by each clear source and register value, the full-range wrap, the sequence of pin levels produced by each action code, PWM duty and period with and without the swap, and that `act_in` is ignored while the timer runs. For these, the bench computes the expected counts and levels arithmetically from the cycle number.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    MD_CMP  = 2'b00,
    MD_TMR  = 2'b01,
    MD_PWM  = 2'b10,
    MD_TMR2 = 2'b11
  } md_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  function automatic logic md_is_timer(input md_e m);
    return (m == MD_TMR) || (m == MD_TMR2);
  endfunction
endpackage

// File: rtl/dct_count.sv
module dct_count #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr_sel_a,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] cmp_p,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_a,
  output logic             hit_p
);
  localparam int LOW_W = CNT_W - PER_W;

  logic [CNT_W-1:0] cnt_inc;
  logic             wrap_now;

  assign cnt_inc = cnt + CNT_W'(1);
  assign hit_a   = (cnt == cmp_a);
  // P match: the next count lands on the coarse boundary (zero value -> full-range overflow)
  assign hit_p   = (cnt_inc[CNT_W-1:LOW_W] == cmp_p) && (cnt_inc[LOW_W-1:0] == '0);
  assign wrap_now = clr_sel_a ? hit_a : hit_p;

  always_ff @(posedge clk) begin
    if (rst || !en)    cnt <= '0;
    else if (wrap_now) cnt <= '0;
    else               cnt <= cnt_inc;
  end
endmodule

// File: rtl/dct_pin.sv
module dct_pin
  import dct_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  md_e              md,
  input  logic             out_ctl,
  input  logic             out_inv,
  input  logic             swap,
  input  logic [1:0]       act_in,
  input  logic             hit_a,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] cmp_p,
  output logic             pin
);
  localparam int LOW_W = CNT_W - PER_W;

  act_e             act_q;
  logic             lvl, lvl_nx;
  logic [CNT_W-1:0] duty;
  logic             pwm_on;
  logic             pin_nx;

  always_ff @(posedge clk) begin
    if (rst)      act_q <= ACT_HOLD;
    else if (!en) act_q <= act_e'(act_in);
  end

  always_comb begin
    lvl_nx = lvl;
    if (!en || md != MD_CMP) begin
      lvl_nx = out_ctl;
    end else if (hit_a) begin
      unique case (act_q)
        ACT_HOLD: lvl_nx = lvl;
        ACT_LOW:  lvl_nx = 1'b0;
        ACT_HIGH: lvl_nx = 1'b1;
        ACT_TOG:  lvl_nx = ~lvl;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= 1'b0;
    else     lvl <= lvl_nx;
  end

  assign duty   = swap ? {cmp_p, {LOW_W{1'b0}}} : cmp_a;
  assign pwm_on = en && (cnt < duty);

  always_comb begin
    if (md_is_timer(md))  pin_nx = 1'b0;
    else if (md == MD_PWM) pin_nx = (pwm_on ? out_ctl : ~out_ctl) ^ out_inv;
    else                   pin_nx = lvl_nx ^ out_inv;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= pin_nx;
  end
endmodule

// File: rtl/dct_flags.sv
module dct_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flg
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst)              q <= 1'b0;
      else if (en && hit[i]) q <= 1'b1;
      else if (clr[i])      q <= 1'b0;
    end
    assign flg[i] = q;
  end
endmodule

// File: rtl/dct_timer.sv
module dct_timer
  import dct_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             clr_on_a,
  input  logic             out_ctl,
  input  logic             out_inv,
  input  logic             swap,
  input  logic [1:0]       act_in,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] cmp_p,
  input  logic             flag_clr_a,
  input  logic             flag_clr_p,
  output logic             pin_out,
  output logic             flag_a,
  output logic             flag_p,
  output logic [CNT_W-1:0] cnt_out
);
  md_e        md;
  logic       clr_sel_a;
  logic       hit_a, hit_p;
  logic [1:0] flg;

  assign md = md_e'(mode);
  // in PWM the swap bit picks which comparator ends the period
  assign clr_sel_a = (md == MD_PWM) ? swap : clr_on_a;

  dct_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .clr_sel_a(clr_sel_a),
    .cmp_a(cmp_a), .cmp_p(cmp_p), .cnt(cnt_out), .hit_a(hit_a), .hit_p(hit_p)
  );

  dct_pin #(.CNT_W(CNT_W), .PER_W(PER_W)) u_pin (
    .clk(clk), .rst(rst), .en(en), .md(md), .out_ctl(out_ctl),
    .out_inv(out_inv), .swap(swap), .act_in(act_in), .hit_a(hit_a),
    .cnt(cnt_out), .cmp_a(cmp_a), .cmp_p(cmp_p), .pin(pin_out)
  );

  dct_flags #(.N(2)) u_flg (
    .clk(clk), .rst(rst), .en(en), .hit({hit_p, hit_a}),
    .clr({flag_clr_p, flag_clr_a}), .flg(flg)
  );

  assign flag_a = flg[0];
  assign flag_p = flg[1];
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       mode,
  input logic             out_ctl,
  input logic             out_inv,
  input logic [CNT_W-1:0] cmp_a,
  input logic [PER_W-1:0] cmp_p,
  input logic             flag_clr_a,
  input logic             flag_clr_p,
  input logic             pin_out,
  input logic             flag_a,
  input logic             flag_p,
  input logic [CNT_W-1:0] cnt_out
);
  logic unused_ok;
  assign unused_ok = ^cmp_p;

  a_r2_stop_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_out == '0));

  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && cnt_out != '0) |-> (cnt_out == CNT_W'($past(cnt_out) + 1'b1)));

  a_r6_sticky_a: assert property (@(posedge clk) disable iff (rst)
    (flag_a && !flag_clr_a) |=> flag_a);

  a_r6_sticky_p: assert property (@(posedge clk) disable iff (rst)
    (flag_p && !flag_clr_p) |=> flag_p);

  a_r6_set_a: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_out == cmp_a) |=> flag_a);

  a_r11_timer_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 || mode == 2'b11) |=> !pin_out);

  a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !en) |=> (pin_out == $past(out_ctl ^ out_inv)));
endmodule

bind dct_timer dct_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .mode(mode), .out_ctl(out_ctl),
  .out_inv(out_inv), .cmp_a(cmp_a), .cmp_p(cmp_p), .flag_clr_a(flag_clr_a),
  .flag_clr_p(flag_clr_p), .pin_out(pin_out), .flag_a(flag_a),
  .flag_p(flag_p), .cnt_out(cnt_out)
);

// File: tb/sim_dct_timer.sv
`timescale 1ns/1ps
module sim_dct_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       clr_on_a = 1'b0;
  logic       out_ctl = 1'b0;
  logic       out_inv = 1'b0;
  logic       swap = 1'b0;
  logic [1:0] act_in = 2'b00;
  logic [9:0] cmp_a = '0;
  logic [2:0] cmp_p = '0;
  logic       flag_clr_a = 1'b0;
  logic       flag_clr_p = 1'b0;
  logic       pin_out, flag_a, flag_p;
  logic [9:0] cnt_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dct_timer u0 (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .clr_on_a(clr_on_a),
    .out_ctl(out_ctl), .out_inv(out_inv), .swap(swap), .act_in(act_in),
    .cmp_a(cmp_a), .cmp_p(cmp_p), .flag_clr_a(flag_clr_a), .flag_clr_p(flag_clr_p),
    .pin_out(pin_out), .flag_a(flag_a), .flag_p(flag_p), .cnt_out(cnt_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // stopped for two edges with both flags cleared; next edge is the first running edge
  task automatic arm();
    en = 1'b0;
    flag_clr_a = 1'b1;
    flag_clr_p = 1'b1;
    tick();
    flag_clr_a = 1'b0;
    flag_clr_p = 1'b0;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int per_list[4];
    tick();
    tick();
    // R1: reset state
    chk(cnt_out == 0 && pin_out == 0 && flag_a == 0 && flag_p == 0, "R1 reset", int'(cnt_out), 0);
    rst = 1'b0;
    tick();
    chk(cnt_out == 0 && pin_out == 0 && flag_a == 0 && flag_p == 0, "R1 after reset", int'(cnt_out), 0);

    // R4 clear on A, R2 stepping and stop, R6 flags
    per_list = '{0, 3, 17, 250};
    mode = 2'b00; clr_on_a = 1'b1; cmp_p = 3'd1;
    foreach (per_list[i]) begin
      cmp_a = 10'(per_list[i]);
      arm();
      en = 1'b1;
      for (int k = 1; k <= 3 * (per_list[i] + 1) && k <= 600; k++) begin
        tick();
        chk(int'(cnt_out) == k % (per_list[i] + 1), "R4 clear on A period", int'(cnt_out), k % (per_list[i] + 1));
        if (per_list[i] == 250 && k == 127) chk(flag_p == 0, "R6 flag_p before P match", flag_p, 0);
        if (per_list[i] == 250 && k == 128) chk(flag_p == 1, "R6 flag_p with A clear source", flag_p, 1);
      end
      chk(flag_a == 1, "R6 flag_a set", flag_a, 1);
      en = 1'b0;
      tick();
      chk(cnt_out == 0, "R2 stop clears count", int'(cnt_out), 0);
      tick();
      chk(cnt_out == 0 && flag_a == 1, "R2 stays zero, R6 flag sticky", int'(cnt_out), 0);
    end
    flag_clr_a = 1'b1;
    tick();
    flag_clr_a = 1'b0;
    chk(flag_a == 0, "R6 flag clear input", flag_a, 0);

    // R4 clear on P, R5 full range
    clr_on_a = 1'b0; cmp_a = 10'd5;
    for (int p = 0; p < 4; p++) begin
      int per;
      cmp_p = (p == 3) ? 3'd0 : 3'(2 * p + 1);
      per = (cmp_p == 0) ? 1024 : 128 * int'(cmp_p);
      arm();
      en = 1'b1;
      for (int k = 1; k <= per + 40; k++) begin
        tick();
        chk(int'(cnt_out) == k % per, (cmp_p == 0) ? "R5 full range wrap" : "R4 clear on P period",
            int'(cnt_out), k % per);
      end
      chk(flag_a == 1 && flag_p == 1, "R6 both flags with P clear source", flag_a + flag_p, 2);
      en = 1'b0;
      tick();
    end

    // R7 action codes, R8 capture while stopped, R10 invert
    mode = 2'b00; clr_on_a = 1'b1; cmp_a = 10'd4;
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 2; c++)
        for (int v = 0; v < 2; v++) begin
          act_in = 2'(a); out_ctl = c[0]; out_inv = v[0];
          arm();
          chk(pin_out == (c[0] ^ v[0]), "R7 initial level R10", pin_out, c ^ v);
          en = 1'b1;
          for (int k = 1; k <= 23; k++) begin
            int m, lv;
            tick();
            act_in = ~2'(a);
            m = k / 5;
            case (a)
              0: lv = c;
              1: lv = (m > 0) ? 0 : c;
              2: lv = (m > 0) ? 1 : c;
              default: lv = c ^ (m & 1);
            endcase
            chk(pin_out == lv[0] ^ v[0], "R7 R8 R10 compare pin", pin_out, lv ^ v);
          end
          en = 1'b0;
          tick();
          chk(pin_out == (c[0] ^ v[0]), "R7 back to initial level", pin_out, c ^ v);
        end

    // R9 PWM, swap=0, clr_on_a ignored
    per_list = '{0, 40, 127, 200};
    mode = 2'b10; swap = 1'b0; clr_on_a = 1'b1; cmp_p = 3'd1;
    foreach (per_list[i])
      for (int c = 0; c < 2; c++)
        for (int v = 0; v < 2; v++) begin
          cmp_a = 10'(per_list[i]); out_ctl = c[0]; out_inv = v[0];
          arm();
          chk(pin_out == (~c[0] ^ v[0]), "R9 stopped inactive", pin_out, (1 - c) ^ v);
          en = 1'b1;
          for (int k = 1; k <= 260; k++) begin
            int on, ex;
            tick();
            on = (((k - 1) % 128) < per_list[i]) ? 1 : 0;
            ex = (on ? c : 1 - c) ^ v;
            chk(int'(cnt_out) == k % 128, "R9 PWM period from P", int'(cnt_out), k % 128);
            chk(pin_out == ex[0], "R9 R10 PWM duty from A", pin_out, ex);
          end
          en = 1'b0;
          tick();
        end

    // R9 PWM, swap=1
    swap = 1'b1; clr_on_a = 1'b0; cmp_a = 10'd300; out_ctl = 1'b1; out_inv = 1'b0;
    for (int p = 1; p < 3; p++) begin
      cmp_p = 3'(p);
      arm();
      en = 1'b1;
      for (int k = 1; k <= 610; k++) begin
        int on;
        tick();
        on = (((k - 1) % 301) < 128 * p) ? 1 : 0;
        chk(int'(cnt_out) == k % 301, "R9 swapped period from A", int'(cnt_out), k % 301);
        chk(int'(pin_out) == on, "R9 swapped duty from P", pin_out, on);
      end
      en = 1'b0;
      tick();
    end
    swap = 1'b0;

    // R3 mode codes, R11 timer pin idle
    cmp_a = 10'd4; clr_on_a = 1'b1; act_in = 2'b11;
    for (int md = 1; md < 4; md += 2)
      for (int v = 0; v < 2; v++) begin
        mode = 2'(md); out_ctl = 1'b1; out_inv = v[0];
        arm();
        en = 1'b1;
        for (int k = 1; k <= 20; k++) begin
          tick();
          chk(int'(cnt_out) == k % 5, "R3 timer mode counts", int'(cnt_out), k % 5);
          chk(pin_out == 0, "R11 timer pin low", pin_out, 0);
        end
        en = 1'b0;
        tick();
      end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule